// File: doc/BRIEF.md
# Memory Self-Test Read Checker

This block checks a region of word-addressed memory that a companion write-side generator has filled. It issues read addresses for a contiguous range and compares each returned word with a pseudo-random value that it regenerates from the word's offset in the range. The read port has an address channel with a valid/ready handshake. It also has a response channel that delivers data in request order and is always accepted. The block counts mismatching words and keeps the address, expected value and returned value of a failing word.

A run begins with a one-cycle start pulse. The base word address, the word count and the stop-on-mismatch flag are sampled at that moment. In stop-on-mismatch mode the block stops at the first bad word, raises done and holds that word's details. A later start pulse continues from the next word, and the error count carries on from where it was. Reads that were already in flight when the block stopped are absorbed without being compared.

The number of reads in flight is limited by a parameter. A memory that answers late therefore never sees more requests than the checker can account for.

Top module: `bist_read_checker`

## Requirements
- R1: After a synchronous reset, done, running, rd_cmd_valid, err_count, err_addr, err_expect and err_actual are all zero.
- R2: A start pulse while the block is neither running nor halted is a fresh start. It samples cfg_base, cfg_length and cfg_halt_on_err and clears err_count and the three capture outputs. Without a halt, it then issues each address from cfg_base to cfg_base+cfg_length-1 exactly once, in ascending order.
- R3: The expected word for offset i (address minus base) is computed as follows, with all arithmetic modulo 2^32. Start with h = (i+1)*0x9E3779B1. Then h = h XOR (h>>16), then h = h*0x85EBCA6B, then h = h XOR (h>>13). A range written with this pattern produces no errors.
- R4: Each compared response that differs from its expected word raises err_count by one. The response also loads err_addr with base plus its offset, err_expect with the expected word and err_actual with the returned word. Without stop-on-mismatch, the run continues, so the capture outputs show the most recent mismatch.
- R5: The cycle after a start pulse is accepted, running is 1 and done is 0. When every word in the range has been compared, running falls and done rises. Both are never high together. A length of zero completes without any read.
- R6: With stop-on-mismatch, the first mismatch drops running and raises done at the same clock edge, and the capture outputs keep that word. No read address is issued until the next start pulse. Responses still in flight are discarded, and err_count does not change.
- R7: A start pulse while halted resumes checking at the word after the failing one, with the address channel restarting at base+offset+1. err_count keeps accumulating, so two stops on two bad words show a count of 2.
- R8: rd_cmd_valid is never high while MAX_OUT reads are outstanding.
- R9: The block never compares more responses than it has issued addresses.
- R10: A start pulse while running has no effect on the address sequence or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse: fresh start or resume |
| cfg_base | input | ADDR_W | First word address of the range |
| cfg_length | input | ADDR_W | Number of words to check |
| cfg_halt_on_err | input | 1 | Stop at the first mismatch |
| rd_cmd_valid | output | 1 | Read address valid |
| rd_cmd_ready | input | 1 | Memory accepts the read address |
| rd_cmd_addr | output | ADDR_W | Read word address |
| rd_rsp_valid | input | 1 | Read data valid, returned in request order |
| rd_rsp_data | input | DATA_W | Read data |
| done | output | 1 | Run finished or halted |
| running | output | 1 | Run in progress |
| err_count | output | CNT_W | Mismatches counted since the last fresh start |
| err_addr | output | ADDR_W | Address of the captured mismatch |
| err_expect | output | DATA_W | Expected word of the captured mismatch |
| err_actual | output | DATA_W | Returned word of the captured mismatch |

## Verification
The hardest situation to reach is a stop that happens while several reads are still outstanding, followed by a resume while some of those stale responses may still be arriving. The stimulus corrupts adjacent words, and in one case the last word of the range. It runs in stop-on-mismatch mode against a memory model that drops the address ready signal at random and returns data after random delays. This keeps the outstanding window at its limit when a mismatch lands. After each stop, a model-derived resume address is compared with the address channel.

// File: rtl/bist_chk_pkg.sv
package bist_chk_pkg;

  localparam int unsigned LANE_W = 32;

  // Integer mixing step that turns a word offset into its test pattern.
  function automatic logic [31:0] bist_mix32(input logic [31:0] seed);
    logic [31:0] h;
    h = (seed + 32'd1) * 32'h9E37_79B1;
    h = h ^ (h >> 16);
    h = h * 32'h85EB_CA6B;
    h = h ^ (h >> 13);
    return h;
  endfunction

endpackage

// File: rtl/bist_pattern_gen.sv
module bist_pattern_gen
  import bist_chk_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] word_idx,
  output logic [DATA_W-1:0] word_exp
);

  localparam int LANES = DATA_W / LANE_W;

  // Each 32-bit lane takes its own seed, so wide words never repeat a lane.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [31:0] seed;
    assign seed = 32'(word_idx) * 32'(LANES) + 32'(k);
    assign word_exp[k*LANE_W +: LANE_W] = bist_mix32(seed);
  end

endmodule

// File: rtl/bist_issue_unit.sv
module bist_issue_unit #(
  parameter int ADDR_W  = 16,
  parameter int MAX_OUT = 4,
  parameter int OUT_W   = $clog2(MAX_OUT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_idx,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] len,
  input  logic              cmd_ready,
  input  logic              rsp_fire,
  output logic              cmd_valid,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              issue_fire,
  output logic [OUT_W-1:0]  out_cnt,
  output logic [ADDR_W-1:0] issue_idx
);

  function automatic logic [OUT_W-1:0] out_next(input logic [OUT_W-1:0] cur,
                                                input logic up, input logic dn);
    return cur + OUT_W'(up) - OUT_W'(dn);
  endfunction

  logic in_range;
  logic window_open;

  assign in_range    = issue_idx < len;
  assign window_open = out_cnt < OUT_W'(MAX_OUT);
  assign cmd_valid   = enable && in_range && window_open;
  assign issue_fire  = cmd_valid && cmd_ready;
  assign cmd_addr    = base + issue_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_idx <= '0;
      out_cnt   <= '0;
    end else begin
      out_cnt <= out_next(out_cnt, issue_fire, rsp_fire);
      if (load)            issue_idx <= load_idx;
      else if (issue_fire) issue_idx <= issue_idx + ADDR_W'(1);
    end
  end

  assert_outstanding_cap_R8: assert property (@(posedge clk) disable iff (rst)
    out_cnt <= OUT_W'(MAX_OUT));

  assert_rsp_has_req_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_fire |-> out_cnt != '0);

endmodule

// File: rtl/bist_capture_unit.sv
module bist_capture_unit #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              hit,
  input  logic [ADDR_W-1:0] hit_addr,
  input  logic [DATA_W-1:0] hit_expect,
  input  logic [DATA_W-1:0] hit_actual,
  output logic [CNT_W-1:0]  err_count,
  output logic [ADDR_W-1:0] err_addr,
  output logic [DATA_W-1:0] err_expect,
  output logic [DATA_W-1:0] err_actual
);

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == '1) ? v : v + CNT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      err_count  <= '0;
      err_addr   <= '0;
      err_expect <= '0;
      err_actual <= '0;
    end else if (hit) begin
      err_count  <= sat_inc(err_count);
      err_addr   <= hit_addr;
      err_expect <= hit_expect;
      err_actual <= hit_actual;
    end
  end

  assert_capture_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!hit && !clear) |=> ($stable(err_addr) && $stable(err_count)));

endmodule

// File: rtl/bist_read_checker.sv
module bist_read_checker
  import bist_chk_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 16,
  parameter int MAX_OUT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_length,
  input  logic              cfg_halt_on_err,
  output logic              rd_cmd_valid,
  input  logic              rd_cmd_ready,
  output logic [ADDR_W-1:0] rd_cmd_addr,
  input  logic              rd_rsp_valid,
  input  logic [DATA_W-1:0] rd_rsp_data,
  output logic              done,
  output logic              running,
  output logic [CNT_W-1:0]  err_count,
  output logic [ADDR_W-1:0] err_addr,
  output logic [DATA_W-1:0] err_expect,
  output logic [DATA_W-1:0] err_actual
);

  localparam int OUT_W = $clog2(MAX_OUT + 1);

  function automatic logic [OUT_W-1:0] stale_after_halt(input logic [OUT_W-1:0] cur,
                                                        input logic issued);
    return cur + OUT_W'(issued) - OUT_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] word_after(input logic [ADDR_W-1:0] idx);
    return idx + ADDR_W'(1);
  endfunction

  logic              halted;
  logic              halt_r;
  logic [ADDR_W-1:0] base_r;
  logic [ADDR_W-1:0] len_r;
  logic [ADDR_W-1:0] data_idx;
  logic [OUT_W-1:0]  discard_cnt;

  logic [ADDR_W-1:0] issue_idx;
  logic [OUT_W-1:0]  out_cnt;
  logic              issue_fire;
  logic [DATA_W-1:0] exp_word;

  // Named internal events.
  logic fresh_start, resume_start, rsp_fire, rsp_discard, rsp_check;
  logic mismatch, halt_evt, finish_evt, cmd_load;
  logic [ADDR_W-1:0] cmd_load_idx;

  assign fresh_start  = start && !running && !halted;
  assign resume_start = start && !running && halted;
  assign rsp_fire     = rd_rsp_valid;
  assign rsp_discard  = rsp_fire && (discard_cnt != '0);
  assign rsp_check    = rsp_fire && (discard_cnt == '0) && running;
  assign mismatch     = rsp_check && (rd_rsp_data != exp_word);
  assign halt_evt     = mismatch && halt_r;
  assign finish_evt   = running && (data_idx == len_r);
  assign cmd_load     = fresh_start || halt_evt;
  assign cmd_load_idx = fresh_start ? '0 : word_after(data_idx);

  bist_pattern_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pattern (
    .word_idx (data_idx),
    .word_exp (exp_word)
  );

  bist_issue_unit #(.ADDR_W(ADDR_W), .MAX_OUT(MAX_OUT), .OUT_W(OUT_W)) u_issue (
    .clk        (clk),
    .rst        (rst),
    .enable     (running),
    .load       (cmd_load),
    .load_idx   (cmd_load_idx),
    .base       (base_r),
    .len        (len_r),
    .cmd_ready  (rd_cmd_ready),
    .rsp_fire   (rsp_fire),
    .cmd_valid  (rd_cmd_valid),
    .cmd_addr   (rd_cmd_addr),
    .issue_fire (issue_fire),
    .out_cnt    (out_cnt),
    .issue_idx  (issue_idx)
  );

  bist_capture_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_capture (
    .clk        (clk),
    .rst        (rst),
    .clear      (fresh_start),
    .hit        (mismatch),
    .hit_addr   (base_r + data_idx),
    .hit_expect (exp_word),
    .hit_actual (rd_rsp_data),
    .err_count  (err_count),
    .err_addr   (err_addr),
    .err_expect (err_expect),
    .err_actual (err_actual)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      running  <= 1'b0;
      done     <= 1'b0;
      halted   <= 1'b0;
      halt_r   <= 1'b0;
      base_r   <= '0;
      len_r    <= '0;
      data_idx <= '0;
    end else if (fresh_start) begin
      base_r   <= cfg_base;
      len_r    <= cfg_length;
      halt_r   <= cfg_halt_on_err;
      data_idx <= '0;
      running  <= 1'b1;
      done     <= 1'b0;
    end else if (resume_start) begin
      halt_r   <= cfg_halt_on_err;
      running  <= 1'b1;
      done     <= 1'b0;
      halted   <= 1'b0;
    end else if (halt_evt) begin
      running  <= 1'b0;
      done     <= 1'b1;
      halted   <= 1'b1;
      data_idx <= word_after(data_idx);
    end else if (finish_evt) begin
      running  <= 1'b0;
      done     <= 1'b1;
    end else if (rsp_check) begin
      data_idx <= word_after(data_idx);
    end
  end

  // Responses already requested when a halt occurs are absorbed here.
  always_ff @(posedge clk) begin
    if (rst)              discard_cnt <= '0;
    else if (halt_evt)    discard_cnt <= stale_after_halt(out_cnt, issue_fire);
    else if (rsp_discard) discard_cnt <= discard_cnt - OUT_W'(1);
  end

  assert_done_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(done && running));

  assert_halt_stops_R6: assert property (@(posedge clk) disable iff (rst)
    halt_evt |=> (done && !running && !rd_cmd_valid));

  assert_quiet_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !running |-> !rd_cmd_valid);

  assert_resume_runs_R7: assert property (@(posedge clk) disable iff (rst)
    resume_start |=> (running && !done));

  assert_count_keeps_R7: assert property (@(posedge clk) disable iff (rst)
    !fresh_start |=> (err_count >= $past(err_count)));

  assert_data_behind_issue_R9: assert property (@(posedge clk) disable iff (rst)
    data_idx <= issue_idx);

  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (running && start) |=> ($stable(base_r) && $stable(len_r)));

endmodule

// File: tb/bist_read_checker_bench.sv
module bist_read_checker_bench;

  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 32;
  localparam int CNT_W   = 16;
  localparam int MAX_OUT = 4;

  logic              clk = 1'b0;
  logic              rst;
  logic              start;
  logic [ADDR_W-1:0] cfg_base;
  logic [ADDR_W-1:0] cfg_length;
  logic              cfg_halt_on_err;
  logic              rd_cmd_valid;
  logic              rd_cmd_ready;
  logic [ADDR_W-1:0] rd_cmd_addr;
  logic              rd_rsp_valid;
  logic [DATA_W-1:0] rd_rsp_data;
  logic              done;
  logic              running;
  logic [CNT_W-1:0]  err_count;
  logic [ADDR_W-1:0] err_addr;
  logic [DATA_W-1:0] err_expect;
  logic [DATA_W-1:0] err_actual;

  always #5 clk = ~clk;

  bist_read_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .MAX_OUT(MAX_OUT))
  u_bist_read_checker (
    .clk(clk), .rst(rst), .start(start), .cfg_base(cfg_base), .cfg_length(cfg_length),
    .cfg_halt_on_err(cfg_halt_on_err), .rd_cmd_valid(rd_cmd_valid),
    .rd_cmd_ready(rd_cmd_ready), .rd_cmd_addr(rd_cmd_addr), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_data(rd_rsp_data), .done(done), .running(running), .err_count(err_count),
    .err_addr(err_addr), .err_expect(err_expect), .err_actual(err_actual)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  logic [31:0] mem [256];
  bit          bad [256];
  logic [15:0] pend_q [$];
  int model_out, exp_addr, addr_bad, r8_bad, r9_bad, n_acc, n_rsp, idle_cmd_seen;
  bit idle_watch;

  // model state
  int base_t, len_t, m_s, m_count, m_addr;
  bit m_halt, m_halted;
  logic [31:0] m_exp, m_act;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  // Golden pattern (R3), 64-bit arithmetic masked back to 32 bits.
  function automatic logic [31:0] golden(input int off);
    logic [63:0] v;
    v = ((64'(off) + 64'd1) * 64'h9E37_79B1) & 64'hFFFF_FFFF;
    v = v ^ (v >> 16);
    v = (v * 64'h85EB_CA6B) & 64'hFFFF_FFFF;
    v = v ^ (v >> 13);
    return v[31:0];
  endfunction

  // One cycle: observe at the falling edge, then drive for the next rising edge.
  task automatic step(input bit do_start);
    bit rdy;
    bit acc;
    logic [15:0] a;
    @(negedge clk);
    if (rd_cmd_valid && model_out >= MAX_OUT) r8_bad++;
    if (idle_watch && rd_cmd_valid) idle_cmd_seen++;
    start = do_start;
    rdy = ($urandom % 4) != 0;
    rd_cmd_ready = rdy;
    acc = rd_cmd_valid && rdy;
    if (acc && int'(rd_cmd_addr) != exp_addr) begin
      if (addr_bad == 0)
        $display("note: address %0d seen where %0d was due", rd_cmd_addr, exp_addr);
      addr_bad++;
    end
    if (pend_q.size() > 0 && ($urandom % 3) != 0) begin
      a = pend_q.pop_front();
      rd_rsp_valid = 1'b1;
      rd_rsp_data  = mem[a[7:0]];
      model_out--;
      n_rsp++;
    end else begin
      rd_rsp_valid = 1'b0;
      rd_rsp_data  = $urandom;
    end
    if (acc) begin
      pend_q.push_back(rd_cmd_addr);
      model_out++;
      exp_addr++;
      n_acc++;
    end
    if (n_rsp > n_acc) r9_bad++;
  endtask

  task automatic model_seg();
    m_halted = 1'b0;
    for (int o = m_s; o < len_t; o++) begin
      if (bad[o]) begin
        m_count++;
        m_addr = base_t + o;
        m_exp  = golden(o);
        m_act  = mem[base_t + o];
        if (m_halt) begin
          m_halted = 1'b1;
          m_s = o + 1;
          break;
        end
      end
    end
    if (!m_halted) m_s = len_t;
  endtask

  task automatic run_case(input string name, input int b, input int l, input bit h,
                          input bit poke);
    int w;
    int seg;
    int acc0;
    base_t = b; len_t = l; m_halt = h;
    for (int a = 0; a < 256; a++) mem[a] = $urandom;
    for (int o = 0; o < l; o++) mem[b + o] = golden(o) ^ (bad[o] ? ($urandom | 32'd1) : 32'd0);
    cfg_base = 16'(b); cfg_length = 16'(l); cfg_halt_on_err = h;
    m_s = 0; m_count = 0; m_addr = 0; m_exp = '0; m_act = '0;
    exp_addr = b; addr_bad = 0; r8_bad = 0; r9_bad = 0; acc0 = n_acc;
    seg = 0;
    do begin
      step(1'b1);
      step(1'b0);
      check(running == 1'b1 && done == 1'b0, "R5", {name, " running after start"},
            {done, running}, 2'b01);
      if (seg == 0)
        check(err_count == '0 && err_addr == '0, "R2", {name, " capture cleared"},
              err_count, 0);
      w = 0;
      while (!done && w < 20000) begin
        step(poke && seg == 0 && w == 5);
        w++;
      end
      model_seg();
      check(done == 1'b1 && running == 1'b0, "R5", {name, " done at end"},
            {done, running}, 2'b10);
      check(err_count == CNT_W'(m_count), m_halted ? "R7" : "R4", {name, " error count"},
            err_count, m_count);
      check(err_addr == ADDR_W'(m_addr), m_halt ? "R6" : "R4", {name, " error address"},
            err_addr, m_addr);
      check(err_expect == m_exp && err_actual == m_act, "R4", {name, " captured words"},
            err_actual, m_act);
      if (m_halted) begin
        idle_watch = 1'b1; idle_cmd_seen = 0;
        repeat (20) step(1'b0);
        idle_watch = 1'b0;
        check(idle_cmd_seen == 0, "R6", {name, " no reads while halted"}, idle_cmd_seen, 0);
        check(err_count == CNT_W'(m_count) && done, "R6", {name, " halted state held"},
              err_count, m_count);
        exp_addr = b + m_s;
      end
      seg++;
    end while (m_halted);
    repeat (30) step(1'b0);
    check(addr_bad == 0, m_halt ? "R7" : "R2", {name, " address order"}, addr_bad, 0);
    if (!m_halt)
      check(n_acc - acc0 == l, "R2", {name, " each address once"}, n_acc - acc0, l);
    check(r8_bad == 0, "R8", {name, " outstanding limit"}, r8_bad, 0);
    check(r9_bad == 0, "R9", {name, " responses within requests"}, r9_bad, 0);
    if (poke)
      check(addr_bad == 0 && n_acc - acc0 == l, "R10", {name, " restart pulse ignored"},
            n_acc - acc0, l);
  endtask

  task automatic clear_bad();
    for (int o = 0; o < 256; o++) bad[o] = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; start = 1'b0; cfg_base = '0; cfg_length = '0; cfg_halt_on_err = 1'b0;
    rd_cmd_ready = 1'b0; rd_rsp_valid = 1'b0; rd_rsp_data = '0;
    model_out = 0; n_acc = 0; n_rsp = 0; idle_watch = 1'b0; idle_cmd_seen = 0;
    clear_bad();
    repeat (3) @(negedge clk);
    check(!done && !running && !rd_cmd_valid && err_count == '0 && err_addr == '0 &&
          err_expect == '0 && err_actual == '0, "R1", "reset state",
          {done, running, rd_cmd_valid}, 0);
    rst = 1'b0;

    run_case("clean_R3", 16, 64, 1'b0, 1'b0);
    bad[4] = 1'b1;
    run_case("one_error", 16, 64, 1'b0, 1'b0);
    bad[5] = 1'b1;
    run_case("two_errors_latest", 16, 64, 1'b0, 1'b0);
    run_case("halt_and_resume", 16, 64, 1'b1, 1'b0);
    clear_bad(); bad[9] = 1'b1;
    run_case("halt_on_last_word", 50, 10, 1'b1, 1'b0);
    clear_bad(); bad[0] = 1'b1; bad[3] = 1'b1;
    run_case("start_while_running", 100, 40, 1'b0, 1'b1);
    clear_bad();
    run_case("empty_range", 30, 0, 1'b0, 1'b0);

    for (int r = 0; r < 8; r++) begin
      int b;
      int l;
      int k;
      b = $urandom % 128;
      l = 1 + ($urandom % 120);
      clear_bad();
      k = $urandom % 4;
      for (int j = 0; j < k; j++) bad[$urandom % l] = 1'b1;
      run_case($sformatf("random_%0d", r), b, l, 1'($urandom % 2), 1'b0);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule